// File: doc/BRIEF.md
# Serial EEPROM Random-Byte Access Sequencer

This block turns a single-byte read or write request into the full chain of byte commands that a serial EEPROM with a two-byte address expects. It sits on top of a byte-level I2C command engine. For each command it raises a one-cycle go strobe with START, STOP, write, read and NACK flags and a transmit byte. It then waits for the engine's completion strobe and examines the acknowledge bit the engine sampled from the slave.

A write sends the device's control byte, both address bytes and the data byte. It then keeps probing the device with its write control byte until the device answers, which shows that the device's internal programming has finished. A read sets the address pointer with a dummy write. It follows with a repeated START, the read control byte and a single received byte closed with NACK and STOP. A missing acknowledge ends the transaction early with a bus release and an error. Writes into the protected top of the address space are refused without touching the bus.

Top module: `eep_seq`

## Requirements
- R1: A write request issues, in order: 0xA0 with START, the high address byte (address zero-extended to 16 bits, bits 15:8), the low address byte, then the data byte with STOP; every one of these has the write flag set.
- R2: A read request issues 0xA0 with START, the high and low address bytes, 0xA1 with START, then one command with read, NACK and STOP set. When done pulses, `rdata` carries the byte the engine returned and `error` is 0. The acknowledge bit of that read command is ignored.
- R3: A command with the write flag that ends with `eng_rxack`=1 (not acknowledged) stops the sequence. No further byte is sent, and a STOP-only command follows (stop=1, start=0, write=0, read=0). Done then pulses with `error`=1.
- R4: After an acknowledged data byte, the block repeats 0xA0 with START until one is acknowledged, then issues a STOP-only command and finishes with `error`=0.
- R5: If `POLL_MAX` consecutive polls (default 8) are all unacknowledged, the block issues a STOP-only command and finishes with `error`=1.
- R6: A write to an address above 16000 issues no engine command. Done pulses in the cycle after acceptance with `error`=1. A write to 16000 itself and a read of 16383 proceed normally.
- R7: `busy` rises in the cycle after a request is accepted and stays high through the single cycle in which `done` is high. `req_valid` is ignored while `busy` is high.
- R8: `eng_go` is high for one cycle per command. It never rises while `busy` is low, and no new command is issued before `eng_done` has answered the previous one.
- R9: After reset, `busy`, `done`, `error`, `eng_go` are 0 and `rdata` is 0.
- R10: `rdata` keeps the last successfully read byte across later writes, aborted reads and refused writes. `error` keeps its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Result of last transaction (1 = failed or refused) |
| rdata | output | 8 | Last byte read |
| eng_go | output | 1 | Command strobe to byte engine |
| eng_start | output | 1 | Command: generate START first |
| eng_stop | output | 1 | Command: generate STOP after |
| eng_wr | output | 1 | Command: transmit `eng_tx` |
| eng_rd | output | 1 | Command: receive one byte |
| eng_nack | output | 1 | Command: answer received byte with NACK |
| eng_tx | output | 8 | Byte to transmit |
| eng_done | input | 1 | Engine finished the current command |
| eng_rxack | input | 1 | Acknowledge bit seen by engine (1 = not acknowledged) |
| eng_rx | input | 8 | Byte received by engine |

## Verification
Reads and writes go through a model of the byte engine that answers after a fixed latency. The model can withhold the acknowledge on a chosen command or on the first N polls. Clean writes and reads check the exact command streams against each other. The abort cases are placed at the control byte, at an address byte, at the data byte and at the read control byte. Comparing the streams of these cases shows that each abort point truncates the sequence at the right spot and appends a bus release. Poll counts of 0, 3, 7 and 8 withheld answers separate a late success from running out the limit. Boundary addresses 16000, 16001 and 16383 separate a refused write from a permitted write and from a permitted read.

// File: rtl/eep_seq_pkg.sv
package eep_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTRL,
      ST_AHI,
      ST_ALO,
      ST_DATA,
      ST_RCTRL,
      ST_RDBYTE,
      ST_POLL,
      ST_STOP,
      ST_FIN
   } step_t;

   typedef struct packed {
      logic       start;
      logic       stop;
      logic       wr;
      logic       rd;
      logic       nack;
      logic [7:0] tx;
   } eng_cmd_t;

endpackage

// File: rtl/eep_addr_guard.sv
module eep_addr_guard #(
   parameter int          ADDR_W     = 14,
   parameter int unsigned PROT_LIMIT = 16000
) (
   input  logic              is_write,
   input  logic [ADDR_W-1:0] addr,
   output logic              reject
);
   localparam int unsigned SPAN = 1 << ADDR_W;

   generate
      if (PROT_LIMIT >= SPAN - 1) begin : g_open
         // limit covers the whole space: nothing to refuse
         assign reject = 1'b0;
      end else begin : g_cut
         assign reject = is_write && (32'(addr) > PROT_LIMIT);
      end
   endgenerate
endmodule

// File: rtl/eep_cmd_map.sv
module eep_cmd_map
   import eep_seq_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
   input  step_t      step,
   input  logic [15:0] addr16,
   input  logic [7:0]  wdata,
   output eng_cmd_t    cmd
);
   localparam logic [7:0] CTRL_WR = {DEV_ADDR, 1'b0};
   localparam logic [7:0] CTRL_RD = {DEV_ADDR, 1'b1};

   always_comb begin
      cmd = '0;
      unique case (step)
         ST_CTRL, ST_POLL: begin
            cmd.start = 1'b1;
            cmd.wr    = 1'b1;
            cmd.tx    = CTRL_WR;
         end
         ST_AHI: begin
            cmd.wr = 1'b1;
            cmd.tx = addr16[15:8];
         end
         ST_ALO: begin
            cmd.wr = 1'b1;
            cmd.tx = addr16[7:0];
         end
         ST_DATA: begin
            cmd.wr   = 1'b1;
            cmd.stop = 1'b1;
            cmd.tx   = wdata;
         end
         ST_RCTRL: begin
            cmd.start = 1'b1;
            cmd.wr    = 1'b1;
            cmd.tx    = CTRL_RD;
         end
         ST_RDBYTE: begin
            cmd.rd   = 1'b1;
            cmd.nack = 1'b1;
            cmd.stop = 1'b1;
         end
         ST_STOP: begin
            cmd.stop = 1'b1;
         end
         default: cmd = '0;
      endcase
   end
endmodule

// File: rtl/eep_poll_cnt.sv
module eep_poll_cnt #(
   parameter int POLL_MAX = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bump,
   output logic last
);
   generate
      if (POLL_MAX == 0) begin : g_unbounded
         logic unused_cnt_in;
         assign unused_cnt_in = &{1'b0, clk, rst_n, clr, bump};
         assign last = 1'b0;
      end else begin : g_bounded
         localparam int CW = (POLL_MAX < 2) ? 1 : $clog2(POLL_MAX);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               cnt_q <= '0;
            end else if (bump) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign last = (cnt_q == CW'(POLL_MAX - 1));
      end
   endgenerate
endmodule

// File: rtl/eep_step_next.sv
module eep_step_next
   import eep_seq_pkg::*;
(
   input  step_t step,
   input  logic  is_write,
   input  logic  rxack,
   input  logic  poll_last,
   output step_t nxt,
   output logic  set_err,
   output logic  poll_clr,
   output logic  poll_bump
);
   always_comb begin
      nxt       = step;
      set_err   = 1'b0;
      poll_clr  = 1'b0;
      poll_bump = 1'b0;
      unique case (step)
         ST_CTRL:   nxt = rxack ? ST_STOP : ST_AHI;
         ST_AHI:    nxt = rxack ? ST_STOP : ST_ALO;
         ST_ALO: begin
            if (rxack)         nxt = ST_STOP;
            else if (is_write) nxt = ST_DATA;
            else               nxt = ST_RCTRL;
         end
         ST_DATA: begin
            nxt      = rxack ? ST_STOP : ST_POLL;
            poll_clr = 1'b1;
         end
         ST_RCTRL:  nxt = rxack ? ST_STOP : ST_RDBYTE;
         ST_RDBYTE: nxt = ST_FIN;
         ST_POLL: begin
            if (!rxack) begin
               nxt = ST_STOP;
            end else if (poll_last) begin
               nxt     = ST_STOP;
               set_err = 1'b1;
            end else begin
               nxt       = ST_POLL;
               poll_bump = 1'b1;
            end
         end
         ST_STOP:   nxt = ST_FIN;
         default:   nxt = ST_IDLE;
      endcase
      if (rxack && (step inside {ST_CTRL, ST_AHI, ST_ALO, ST_DATA, ST_RCTRL}))
         set_err = 1'b1;
   end
endmodule

// File: rtl/eep_seq.sv
module eep_seq
   import eep_seq_pkg::*;
#(
   parameter int          ADDR_W     = 14,
   parameter int unsigned PROT_LIMIT = 16000,
   parameter int          POLL_MAX   = 8,
   parameter logic [6:0]  DEV_ADDR   = 7'b1010000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_wdata,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [7:0]        rdata,
   output logic              eng_go,
   output logic              eng_start,
   output logic              eng_stop,
   output logic              eng_wr,
   output logic              eng_rd,
   output logic              eng_nack,
   output logic [7:0]        eng_tx,
   input  logic              eng_done,
   input  logic              eng_rxack,
   input  logic [7:0]        eng_rx
);
   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
         $error("eep_seq: ADDR_W must lie in 9..16");
      end
      if (POLL_MAX < 0) begin : g_bad_poll
         $error("eep_seq: POLL_MAX must not be negative");
      end
   endgenerate

   step_t             st_q;
   logic              wait_q;
   logic              err_q;
   logic [7:0]        rdata_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic [7:0]        wd_q;

   logic     reject;
   logic     in_cmd;
   eng_cmd_t cmd;
   step_t    nxt;
   logic     set_err, poll_clr, poll_bump, poll_last;
   logic     step_end;

   eep_addr_guard #(.ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT)) u_guard (
      .is_write (req_write),
      .addr     (req_addr),
      .reject   (reject)
   );

   eep_cmd_map #(.DEV_ADDR(DEV_ADDR)) u_map (
      .step   (st_q),
      .addr16 (16'(addr_q)),
      .wdata  (wd_q),
      .cmd    (cmd)
   );

   eep_step_next u_next (
      .step      (st_q),
      .is_write  (wr_q),
      .rxack     (eng_rxack),
      .poll_last (poll_last),
      .nxt       (nxt),
      .set_err   (set_err),
      .poll_clr  (poll_clr),
      .poll_bump (poll_bump)
   );

   assign in_cmd   = !(st_q inside {ST_IDLE, ST_FIN});
   assign step_end = in_cmd && wait_q && eng_done;

   eep_poll_cnt #(.POLL_MAX(POLL_MAX)) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (step_end && poll_clr),
      .bump  (step_end && poll_bump),
      .last  (poll_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         wait_q  <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
         addr_q  <= '0;
         wr_q    <= 1'b0;
         wd_q    <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q <= req_addr;
                  wr_q   <= req_write;
                  wd_q   <= req_wdata;
                  wait_q <= 1'b0;
                  err_q  <= reject;
                  st_q   <= reject ? ST_FIN : ST_CTRL;
               end
            end
            ST_FIN: st_q <= ST_IDLE;
            default: begin
               if (!wait_q) begin
                  wait_q <= 1'b1;
               end else if (eng_done) begin
                  wait_q <= 1'b0;
                  st_q   <= nxt;
                  if (set_err)          err_q   <= 1'b1;
                  if (st_q == ST_RDBYTE) rdata_q <= eng_rx;
               end
            end
         endcase
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign done      = (st_q == ST_FIN);
   assign error     = err_q;
   assign rdata     = rdata_q;
   assign eng_go    = in_cmd && !wait_q;
   assign eng_start = cmd.start;
   assign eng_stop  = cmd.stop;
   assign eng_wr    = cmd.wr;
   assign eng_rd    = cmd.rd;
   assign eng_nack  = cmd.nack;
   assign eng_tx    = cmd.tx;
endmodule

// File: rtl/eep_seq_chk.sv
module eep_seq_chk #(
   parameter int          ADDR_W     = 14,
   parameter int unsigned PROT_LIMIT = 16000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              busy,
   input logic              done,
   input logic              error,
   input logic              eng_go,
   input logic              eng_start,
   input logic              eng_stop,
   input logic              eng_wr,
   input logic              eng_rd,
   input logic              eng_nack
);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   // R7
   busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   // R8
   go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |=> !eng_go);
   // R8
   go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |-> busy);
   // R6
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && req_write && (32'(req_addr) > PROT_LIMIT))
      |=> (done && error && !eng_go));
   // R2
   read_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_go && eng_rd) |-> (eng_stop && eng_nack && !eng_start && !eng_wr));
   // R3
   stop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_go && !eng_wr && !eng_rd) |-> (eng_stop && !eng_start));
endmodule

bind eep_seq eep_seq_chk #(.ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT)) u_eep_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .busy      (busy),
   .done      (done),
   .error     (error),
   .eng_go    (eng_go),
   .eng_start (eng_start),
   .eng_stop  (eng_stop),
   .eng_wr    (eng_wr),
   .eng_rd    (eng_rd),
   .eng_nack  (eng_nack)
);

// File: tb/test_eep_seq.sv
module test_eep_seq;
   localparam int AW   = 14;
   localparam int PMAX = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_wdata = '0;
   logic          busy, done, error;
   logic [7:0]    rdata;
   logic          eng_go, eng_start, eng_stop, eng_wr, eng_rd, eng_nack;
   logic [7:0]    eng_tx;
   logic          eng_done = 1'b0;
   logic          eng_rxack = 1'b0;
   logic [7:0]    eng_rx = 8'h00;

   always #10 clk = ~clk;

   eep_seq #(.ADDR_W(AW), .PROT_LIMIT(16000), .POLL_MAX(PMAX)) i_eep_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .error(error), .rdata(rdata), .eng_go(eng_go), .eng_start(eng_start),
      .eng_stop(eng_stop), .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_nack(eng_nack),
      .eng_tx(eng_tx), .eng_done(eng_done), .eng_rxack(eng_rxack), .eng_rx(eng_rx)
   );

   int n_chk = 0;
   int n_bad = 0;

   // engine model: flags {start, stop, wr, rd, nack}
   logic [4:0] log_f [64];
   logic [7:0] log_b [64];
   int         n_log = 0;
   int         base  = 0;
   int         cur_nack_at = 99;
   int         cur_pnack = 0;
   logic       cur_wr = 1'b0;
   int         cd = 0;
   logic       pend_ack = 1'b0;
   logic [7:0] pend_rx = 8'h00;

   always @(posedge clk) begin
      if (!rst_n) begin
         eng_done <= 1'b0;
         cd       <= 0;
      end else begin
         eng_done <= 1'b0;
         if (eng_go) begin
            int idx;
            idx = n_log - base;
            log_f[n_log % 64] <= {eng_start, eng_stop, eng_wr, eng_rd, eng_nack};
            log_b[n_log % 64] <= eng_tx;
            n_log   <= n_log + 1;
            cd      <= 3;
            pend_ack <= (idx == cur_nack_at) || eng_rd ||
                        (cur_wr && idx >= 4 && eng_start && (idx - 4) < cur_pnack);
            pend_rx  <= eng_rd ? (8'(req_addr_lat) ^ 8'h5A) : 8'hEE;
         end else if (cd != 0) begin
            cd <= cd - 1;
            if (cd == 1) begin
               eng_done  <= 1'b1;
               eng_rxack <= pend_ack;
               eng_rx    <= pend_rx;
            end
         end
      end
   end

   logic [AW-1:0] req_addr_lat = '0;

   logic [4:0] exp_f [32];
   logic [7:0] exp_b [32];
   int         exp_n;
   logic       exp_err;
   logic [7:0] exp_rdata = 8'h00;

   task automatic push(input logic [4:0] f, input logic [7:0] b);
      exp_f[exp_n] = f;
      exp_b[exp_n] = b;
      exp_n++;
   endtask

   // expected command stream built from R1..R5
   task automatic build(input logic wr, input logic [AW-1:0] a, input logic [7:0] d,
                        input int nack_at, input int pnack);
      logic [15:0] a16;
      a16 = 16'(a);
      exp_n = 0;
      exp_err = 1'b0;
      push(5'b10100, 8'hA0);
      if (nack_at == 0) begin push(5'b01000, 8'h00); exp_err = 1'b1; return; end
      push(5'b00100, a16[15:8]);
      if (nack_at == 1) begin push(5'b01000, 8'h00); exp_err = 1'b1; return; end
      push(5'b00100, a16[7:0]);
      if (nack_at == 2) begin push(5'b01000, 8'h00); exp_err = 1'b1; return; end
      if (wr) begin
         push(5'b01100, d);
         if (nack_at == 3) begin push(5'b01000, 8'h00); exp_err = 1'b1; return; end
         for (int k = 0; k < PMAX; k++) begin
            push(5'b10100, 8'hA0);
            if (k >= pnack) break;
         end
         if (pnack >= PMAX) exp_err = 1'b1;
         push(5'b01000, 8'h00);
      end else begin
         push(5'b10100, 8'hA1);
         if (nack_at == 3) begin push(5'b01000, 8'h00); exp_err = 1'b1; return; end
         push(5'b01011, 8'h00);
         exp_rdata = 8'(a) ^ 8'h5A;
      end
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic wr, input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      req_addr_lat = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int t;
      t = 0;
      while (!done && t < 2000) begin @(negedge clk); t++; end
      check(req, "watchdog on done", int'(done), 1);
   endtask

   task automatic cmp_log(input string req);
      int bad_at;
      bad_at = -1;
      check(req, "command count", n_log - base, exp_n);
      for (int i = 0; i < exp_n && i < n_log - base; i++) begin
         if (bad_at < 0 && (log_f[(base + i) % 64] != exp_f[i] || log_b[(base + i) % 64] != exp_b[i]))
            bad_at = i;
      end
      if (bad_at >= 0)
         check(req, "command content", {log_f[(base + bad_at) % 64], log_b[(base + bad_at) % 64]},
               {exp_f[bad_at], exp_b[bad_at]});
      else
         check(req, "command content", 0, 0);
   endtask

   task automatic run(input logic wr, input logic [AW-1:0] a, input logic [7:0] d,
                      input int nack_at, input int pnack, input string req);
      base = n_log; cur_wr = wr; cur_nack_at = nack_at; cur_pnack = pnack;
      build(wr, a, d, nack_at, pnack);
      send(wr, a, d);
      wait_done(req);
      check(req, "error", int'(error), int'(exp_err));
      check("R10", "rdata", int'(rdata), int'(exp_rdata));
      @(negedge clk);
      check("R7", "busy after done", int'(busy), 0);
      cmp_log(req);
   endtask

   // {wr, addr[13:0], data[7:0], nack_at[3:0] (15 = none), pnack[3:0]}
   localparam logic [30:0] VEC [10] = '{
      {1'b1, 14'h0123, 8'hB6, 4'd15, 4'd0},  // R1 R4
      {1'b1, 14'h2A5C, 8'h3C, 4'd15, 4'd3},  // R4 late ack
      {1'b0, 14'h0929, 8'h00, 4'd15, 4'd0},  // R2
      {1'b0, 14'h3FFF, 8'h00, 4'd15, 4'd0},  // R2 R6 top read
      {1'b1, 14'h3E80, 8'h7E, 4'd15, 4'd8},  // R5 R6 write at 16000
      {1'b1, 14'h0010, 8'h55, 4'd1,  4'd0},  // R3 high address
      {1'b0, 14'h1234, 8'h00, 4'd3,  4'd0},  // R3 read control
      {1'b1, 14'h0456, 8'h99, 4'd3,  4'd0},  // R3 data byte
      {1'b0, 14'h0000, 8'h00, 4'd0,  4'd0},  // R3 first control
      {1'b1, 14'h0001, 8'hC3, 4'd15, 4'd7}   // R4 ack on last allowed poll
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9
      check("R9", "busy", int'(busy), 0);
      check("R9", "done", int'(done), 0);
      check("R9", "error", int'(error), 0);
      check("R9", "eng_go", int'(eng_go), 0);
      check("R9", "rdata", int'(rdata), 0);

      for (int v = 0; v < 10; v++) begin
         logic [30:0] e;
         int na;
         string tag;
         e  = VEC[v];
         na = (e[7:4] == 4'd15) ? 99 : int'(e[7:4]);
         if (na != 99)                tag = "R3";
         else if (e[30] && e[3:0] >= PMAX) tag = "R5";
         else if (e[30] && e[3:0] > 0)     tag = "R4";
         else if (e[30])                   tag = "R1";
         else                              tag = "R2";
         run(e[30], e[29:16], e[15:8], na, int'(e[3:0]), tag);
      end

      // R6: refused writes above 16000, no engine activity
      for (int r = 0; r < 2; r++) begin
         logic [AW-1:0] ra;
         ra = (r == 0) ? 14'd16001 : 14'd16383;
         base = n_log;
         @(negedge clk);
         req_valid = 1'b1; req_write = 1'b1; req_addr = ra; req_wdata = 8'h12;
         @(negedge clk);
         req_valid = 1'b0;
         check("R6", "done after refuse", int'(done), 1);
         check("R6", "error after refuse", int'(error), 1);
         check("R10", "rdata kept on refuse", int'(rdata), int'(exp_rdata));
         @(negedge clk);
         check("R7", "busy after refuse", int'(busy), 0);
         repeat (5) @(negedge clk);
         check("R6", "no engine command", n_log - base, 0);
      end

      // R7: request while busy is ignored
      base = n_log; cur_wr = 1'b1; cur_nack_at = 99; cur_pnack = 0;
      build(1'b1, 14'h0200, 8'h11, 99, 0);
      send(1'b1, 14'h0200, 8'h11);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 14'h3333;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_done("R7");
      check("R7", "error", int'(error), 0);
      @(negedge clk);
      repeat (10) @(negedge clk);
      check("R7", "idle after ignored request", int'(busy), 0);
      cmp_log("R7");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule